// File: doc/BRIEF.md
# Serial Latch Receiver for a Frequency Synthesizer

This block is the register-load front end of an integer-N frequency synthesizer. A host drives three slow, asynchronous lines: a serial clock, a serial data bit and a load strobe. The block brings these lines into the system clock domain and shifts each data bit in on a rising serial clock, most significant bit first. On a rising load strobe it copies the assembled word into one of four holding latches, which are the reference divider, the main divider, the function settings and the initialization settings.

The two least significant bits of the word, which are the last two bits shifted in, pick the destination latch. The contents of the latches are decoded into parallel outputs for the rest of the synthesizer: the reference divide ratio and its lock-detect precision bit, the swallow (A) and main (B) counter values, and the charge-pump gain bit. The function and initialization payloads are exposed as raw mode bits. A write to the initialization latch also fires a one-cycle pulse that resets the reference and main counters. The parameter `WORD_W` selects a 21-bit word with a 5-bit A field or a 24-bit word with a 6-bit A field.

Top module: `synth_word_rx`

## Requirements
- R1: After reset every output is zero: `ref_div_o`, `ref_ldp_o`, `a_val_o`, `b_val_o`, `gain_o`, `func_bits_o`, `init_bits_o` and `cnt_rst_o`.
- R2: Each rising edge of `ser_clk_i` shifts the current `ser_dat_i` into the low end of a `WORD_W`-bit shift register, so the first bit sent ends up most significant. When more than `WORD_W` bits are sent, only the last `WORD_W` bits are kept.
- R3: A rising edge of `ser_le_i` copies the word into the latch named by word bits [1:0]: 2'b00 is the reference latch, 2'b01 the main latch, 2'b10 the function latch and 2'b11 the initialization latch.
- R4: A load changes only the addressed latch. The outputs decoded from the other three latches keep their values.
- R5: The reference latch drives `ref_div_o` from word bits [15:2] and `ref_ldp_o` from word bit 20.
- R6: The main latch drives the A field from word bits [A_W+1:2], the 13-bit B field from the next 13 bits, and `gain_o` from the bit just above B. A_W is 5 when `WORD_W`=21 and 6 when `WORD_W`=24. In the 24-bit variant this puts A at [7:2], B at [20:8] and gain at 21. `a_val_o` is 6 bits wide, and its top bit is zero in the 21-bit variant.
- R7: An initialization load raises `cnt_rst_o` for exactly one system clock cycle. The pulse starts in the same cycle the initialization outputs update. Loads of the other three latches raise no pulse.
- R8: `func_bits_o` and `init_bits_o` present word bits [WORD_W-1:2] of the last function load and the last initialization load.
- R9: Between loads all latch outputs hold their values. Serial clocking without a load strobe changes no output.
- R10: A loaded word appears on the outputs after the third system clock rising edge at which `ser_le_i` is seen high, counting the first such edge as one. If a serial clock edge and a load edge are seen in the same cycle, the latch receives the word as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data bit, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous; rising edge latches the word |
| ref_div_o | output | 14 | Reference divide ratio |
| ref_ldp_o | output | 1 | Lock-detect precision select (1 = five cycles) |
| a_val_o | output | 6 | Swallow counter value |
| b_val_o | output | 13 | Main counter value |
| gain_o | output | 1 | Charge-pump gain/current select bit |
| func_bits_o | output | WORD_W-2 | Function latch payload |
| init_bits_o | output | WORD_W-2 | Initialization latch payload |
| cnt_rst_o | output | 1 | One-cycle counter reset pulse on an initialization load |

## Verification
The case that needs care is a rising serial clock and a rising load strobe reaching the receiver in the same synchronized cycle. In that cycle the shift register moves and a latch loads from it at once. The bench provokes this by raising both lines on the same system clock edge after a full word has been sent. It then checks that the reference latch holds the word from before the extra shift, and a bench model that loads before it shifts follows this on every cycle. The same per-cycle model also tracks when the counter reset pulse lines up with the initialization latch update.

// File: rtl/syl_pkg.sv
package syl_pkg;

   typedef enum logic [1:0] {
      LT_REF  = 2'b00,
      LT_MAIN = 2'b01,
      LT_FUNC = 2'b10,
      LT_INIT = 2'b11
   } latch_e;

   localparam int unsigned B_FIELD_W = 13;
   localparam int unsigned R_FIELD_W = 14;
   localparam int unsigned LDP_WBIT  = 20;

   function automatic int unsigned a_width(input int unsigned word_w);
      return (word_w == 24) ? 6 : 5;
   endfunction

endpackage

// File: rtl/syl_sync.sv
module syl_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("syl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES:0] pipe;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[STAGES-1:0], raw_i[i]};
      end

      assign lvl_o[i]  = pipe[STAGES-1];
      assign rise_o[i] = pipe[STAGES-1] & ~pipe[STAGES];

      // R10: a detected edge cannot repeat in the next cycle
      assert_rise_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[i] |=> !rise_o[i]);
   end

endmodule

// File: rtl/syl_shreg.sv
module syl_shreg #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] word_o
);

   if (W < 4) begin : g_bad_w
      $error("syl_shreg: W too small");
   end

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[W-2:0], bit_i};
   end

   assign word_o = sr_q;

   // R2: the new bit lands at the low end after a shift
   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (word_o[0] == $past(bit_i)));

endmodule

// File: rtl/syl_latches.sv
module syl_latches
   import syl_pkg::*;
#(
   parameter int unsigned W   = 24,
   parameter int unsigned A_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [W-1:0]     word_i,
   output logic [13:0]      ref_div_o,
   output logic             ref_ldp_o,
   output logic [5:0]       a_val_o,
   output logic [12:0]      b_val_o,
   output logic             gain_o,
   output logic [W-3:0]     func_bits_o,
   output logic [W-3:0]     init_bits_o,
   output logic             cnt_rst_o
);

   localparam int unsigned PW      = W - 2;
   localparam int unsigned NLATCH  = 4;
   localparam int unsigned LDP_P   = LDP_WBIT - 2;
   localparam int unsigned GAIN_P  = A_W + B_FIELD_W;

   if (A_W < 5 || A_W > 6) begin : g_bad_aw
      $error("syl_latches: A_W must be 5 or 6");
   end
   if (PW < GAIN_P + 1 || PW < LDP_P + 1) begin : g_bad_pw
      $error("syl_latches: word too short for fields");
   end

   latch_e           sel;
   logic [NLATCH-1:0] wr;
   logic [PW-1:0]    st_q [NLATCH];
   logic             pulse_q;

   assign sel = latch_e'(word_i[1:0]);
   assign wr  = load_i ? (NLATCH'(1) << sel) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NLATCH; g++) st_q[g] <= '0;
         pulse_q <= 1'b0;
      end else begin
         for (int g = 0; g < NLATCH; g++)
            if (wr[g]) st_q[g] <= word_i[W-1:2];
         pulse_q <= wr[LT_INIT];
      end
   end

   assign ref_div_o   = st_q[LT_REF][R_FIELD_W-1:0];
   assign ref_ldp_o   = st_q[LT_REF][LDP_P];
   assign b_val_o     = st_q[LT_MAIN][A_W +: B_FIELD_W];
   assign gain_o      = st_q[LT_MAIN][GAIN_P];
   assign func_bits_o = st_q[LT_FUNC];
   assign init_bits_o = st_q[LT_INIT];
   assign cnt_rst_o   = pulse_q;

   if (A_W == 6) begin : g_a6
      assign a_val_o = st_q[LT_MAIN][5:0];
   end else begin : g_a5
      assign a_val_o = {1'b0, st_q[LT_MAIN][4:0]};
   end

   logic unused_fields;
   assign unused_fields = ^{st_q[LT_REF], st_q[LT_MAIN]};

   // R7: an initialization load yields the pulse next cycle
   assert_init_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && word_i[1:0] == 2'b11) |=> cnt_rst_o);

   // R7: the pulse lasts one cycle
   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_o |=> !cnt_rst_o);

   // R9: no load, no change
   assert_ref_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(ref_div_o) && $stable(b_val_o) && $stable(func_bits_o)));

   // R4: a load aimed elsewhere leaves the reference outputs alone
   assert_other_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && word_i[1:0] != 2'b00) |=> ($stable(ref_div_o) && $stable(ref_ldp_o)));

endmodule

// File: rtl/synth_word_rx.sv
module synth_word_rx
   import syl_pkg::*;
#(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              ser_le_i,
   output logic [13:0]       ref_div_o,
   output logic              ref_ldp_o,
   output logic [5:0]        a_val_o,
   output logic [12:0]       b_val_o,
   output logic              gain_o,
   output logic [WORD_W-3:0] func_bits_o,
   output logic [WORD_W-3:0] init_bits_o,
   output logic              cnt_rst_o
);

   localparam int unsigned A_W = a_width(WORD_W);

   if (WORD_W != 21 && WORD_W != 24) begin : g_bad_word
      $error("synth_word_rx: WORD_W must be 21 or 24");
   end

   logic [2:0]        lvl, rise;
   logic [WORD_W-1:0] word;

   syl_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({ser_le_i, ser_dat_i, ser_clk_i}),
      .lvl_o  (lvl),
      .rise_o (rise)
   );

   syl_shreg #(.W(WORD_W)) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (rise[0]),
      .bit_i   (lvl[1]),
      .word_o  (word)
   );

   syl_latches #(.W(WORD_W), .A_W(A_W)) u_lat (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (rise[2]),
      .word_i      (word),
      .ref_div_o   (ref_div_o),
      .ref_ldp_o   (ref_ldp_o),
      .a_val_o     (a_val_o),
      .b_val_o     (b_val_o),
      .gain_o      (gain_o),
      .func_bits_o (func_bits_o),
      .init_bits_o (init_bits_o),
      .cnt_rst_o   (cnt_rst_o)
   );

   logic unused_sync;
   assign unused_sync = ^{rise[1], lvl[0], lvl[2]};

endmodule

// File: tb/sim_synth_word_rx.sv
module sim_synth_word_rx;

   localparam int BW   = 24;
   localparam int AW   = 6;
   localparam int HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [13:0]   ref_div;
   logic          ref_ldp, gain, cnt_rst;
   logic [5:0]    a_val;
   logic [12:0]   b_val;
   logic [BW-3:0] func_bits, init_bits;

   int total = 0, bad = 0, cyc = 0, npulse = 0;
   bit done = 0;

   always #10 clk = ~clk;

   synth_word_rx #(.WORD_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
      .ref_div_o(ref_div), .ref_ldp_o(ref_ldp), .a_val_o(a_val),
      .b_val_o(b_val), .gain_o(gain), .func_bits_o(func_bits),
      .init_bits_o(init_bits), .cnt_rst_o(cnt_rst)
   );

   // behavioural reference: history of line samples, word store per code
   logic [3:0]    hs, hd, hl;
   logic [BW-1:0] m_sr;
   logic [BW-1:0] m_word [4];
   logic          m_pulse;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs = '0; hd = '0; hl = '0; m_sr = '0; m_pulse = 1'b0;
         for (int k = 0; k < 4; k++) m_word[k] = '0;
      end else begin
         hs = {hs[2:0], ser_clk};
         hd = {hd[2:0], ser_dat};
         hl = {hl[2:0], ser_le};
         m_pulse = 1'b0;
         if (hl[2] && !hl[3]) begin
            m_word[m_sr[1:0]] = m_sr;
            m_pulse = (m_sr[1:0] == 2'b11);
         end
         if (hs[2] && !hs[3]) m_sr = {m_sr[BW-2:0], hd[2]};
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(32'(ref_div), 32'(m_word[0][15:2]), "R5 ref divide per cycle");
         chk(32'(ref_ldp), 32'(m_word[0][20]), "R5 precision per cycle");
         chk(32'(a_val), 32'(m_word[1][AW+1:2]), "R6 A field per cycle");
         chk(32'(b_val), 32'(m_word[1][AW+14:AW+2]), "R6 B field per cycle");
         chk(32'(gain), 32'(m_word[1][AW+15]), "R6 gain per cycle");
         chk(32'(func_bits), 32'(m_word[2][BW-1:2]), "R8 function per cycle");
         chk(32'(init_bits), 32'(m_word[3][BW-1:2]), "R8 init per cycle");
         chk(32'(cnt_rst), 32'(m_pulse), "R7 pulse timing R10");
         if (cnt_rst) npulse++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic shift_bit(input logic b);
      ser_dat = b; ser_clk = 1'b0;
      repeat (HOLD) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
   endtask

   task automatic strobe();
      ser_clk = 1'b0; ser_le = 1'b1;
      repeat (HOLD) @(negedge clk);
      ser_le = 1'b0;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic load(input logic [BW-1:0] w);
      send_bits(32'(w), BW);
      strobe();
   endtask

   logic [BW-1:0] w_ref, w_main, w_func, w_init;
   int p0;

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset values
      chk(32'(ref_div), 0, "R1 ref_div");
      chk(32'(a_val) | 32'(b_val) | 32'(gain) | 32'(ref_ldp), 0, "R1 main/ldp");
      chk(32'(func_bits) | 32'(init_bits) | 32'(cnt_rst), 0, "R1 func/init/pulse");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 R5: reference latch, R=10, five-cycle precision
      w_ref = BW'((1 << 20) | (10 << 2) | 0);
      p0 = npulse;
      load(w_ref);
      chk(32'(ref_div), 10, "R5 ref_div");
      chk(32'(ref_ldp), 1, "R5 ref_ldp");
      chk(32'(npulse - p0), 0, "R7 no pulse on ref load");

      // R6: main latch, A=8, B=31, gain=1
      w_main = BW'((1 << 21) | (31 << 8) | (8 << 2) | 1);
      load(w_main);
      chk(32'(a_val), 8, "R6 A");
      chk(32'(b_val), 31, "R6 B");
      chk(32'(gain), 1, "R6 gain");
      chk(32'(ref_div), 10, "R4 ref kept after main load");

      // R8: function latch
      w_func = BW'((22'h155AA5 << 2) | 2);
      load(w_func);
      chk(32'(func_bits), 32'h155AA5, "R8 func_bits");
      chk(32'(b_val), 31, "R4 main kept after func load");

      // R7: initialization latch and its pulse
      w_init = BW'((22'h0ABC12 << 2) | 3);
      p0 = npulse;
      load(w_init);
      chk(32'(init_bits), 32'h0ABC12, "R8 init_bits");
      chk(32'(npulse - p0), 1, "R7 single pulse");
      chk(32'(func_bits), 32'h155AA5, "R4 func kept after init load");

      // R9: clocking without strobe changes nothing
      send_bits(32'hFFFFFF, BW);
      repeat (6) @(negedge clk);
      chk(32'(ref_div), 10, "R9 ref held");
      chk(32'(a_val), 8, "R9 A held");
      chk(32'(init_bits), 32'h0ABC12, "R9 init held");

      // R2: extra leading bits fall off; R=16383, precision 0
      send_bits(32'h2D, 6);
      load(BW'((16383 << 2) | 0));
      chk(32'(ref_div), 16383, "R2 last bits kept");
      chk(32'(ref_ldp), 0, "R2 precision cleared");

      // R10: serial edge and strobe in the same cycle
      send_bits(32'((3 << 2) | 0), BW);
      ser_clk = 1'b0; ser_dat = 1'b1;
      repeat (HOLD) @(negedge clk);
      ser_clk = 1'b1; ser_le = 1'b1;
      repeat (HOLD) @(negedge clk);
      ser_clk = 1'b0; ser_le = 1'b0;
      repeat (HOLD) @(negedge clk);
      chk(32'(ref_div), 3, "R10 load uses pre-shift word");

      // R3: main load with other values, 6-bit A at its top
      load(BW'((0 << 21) | (8191 << 8) | (63 << 2) | 1));
      chk(32'(a_val), 63, "R3 A max");
      chk(32'(b_val), 8191, "R3 B max");
      chk(32'(gain), 0, "R3 gain low");

      repeat (10) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule